// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block collects a parameterised set of interrupt sources and steers each of them to one output line of one processor. Every source holds four pieces of state: a pending flag, an enable flag, an output-pin selection and a processor selection. The outputs form a processor-by-pin array. Each output is high while at least one source steered to that processor and pin is both enabled and pending.

A source becomes pending in one of two ways. A change in the level of its hardware input copies the new level into the pending flag. A write to the trigger register names a source and says whether to raise or drop its pending flag. Enables are never written directly: one register range turns enables on and another turns them off. Every access goes through a simple word-wide register bus. Write data is taken on the same clock edge as the write. Read data appears one clock after the read request.

The processor selection is written as a one-hot word and kept as an index, taken from the lowest set bit. It is read back as a one-hot word. A configuration word reports how many sources and processors are built in.

Top module: `sirq_router`

## Requirements
- R1: A read of byte address 0x000 returns the source count code (NUM_SRC/8 - 1) in bits [15:8], NUM_CPU in bits [7:0], and zero in every other bit.
- R2: After reset the state is as follows. All enables and pending flags are 0. Each pin word reads 0x80000000 (route flag set, pin index 0). Each processor slot reads 0. Every output is 0.
- R3: A write to the set-enable word at 0x180 + 4*w enables source 32*w+b for each data bit b that is 1. Bits that are 0 leave their enable unchanged. The enable bitmap is read at 0x140 + 4*w, and bit b of that word is source 32*w+b.
- R4: A write to the clear-enable word at 0x1C0 + 4*w disables source 32*w+b for each data bit b that is 1. Bits that are 0 change nothing.
- R5: The pending bitmap is read at 0x100 + 4*w, and bit b of that word is source 32*w+b. A bitmap word w with 32*(w+1) > NUM_SRC is rejected. Reads of a rejected word return 0, and set-enable or clear-enable writes to it change nothing.
- R6: The pin word of source s is at 0x400 + 4*s. Bit 31 is the route flag and bits [5:0] are the pin index. Only these bits are stored. A write whose index is NUM_PIN or more is ignored.
- R7: The processor slot of source s covers the 32 bytes from 0x2000 + 32*s. A write stores the position of the lowest set data bit. A zero write leaves the source steered to no processor. A write whose lowest set bit is at NUM_CPU or above is ignored. A read returns 1 << index, or 0 when the source is steered to no processor.
- R8: A write to the trigger register at 0x004 takes the source number from data bits [30:0]. Data bit 31 = 1 sets that source's pending flag and bit 31 = 0 clears it. A source number of NUM_SRC or more changes nothing.
- R9: When the level of src_in[s] differs from its level at the previous clock edge, the pending flag of s takes the new level. Such a change wins over a trigger write to the same source in the same cycle.
- R10: Output irq_out[c*NUM_PIN+p] is the OR of pending AND enabled over all sources steered to processor c and pin index p. The route flag plays no part. The output reflects a state change right after the edge that made the change.
- R11: Read data is registered: bus_rdata changes only after an edge that took a read. Reads of unused addresses, write-only ranges or addresses not aligned to a word return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| src_in | input | NUM_SRC | Hardware level of each source |
| irq_out | output | NUM_CPU*NUM_PIN | Per-processor, per-pin interrupt lines |

## Verification
Writes and hardware level changes take effect on the rising edge that samples them. The outputs are formed without registers from the stored state, so a new output value is due right after that same edge. A read returns its data on bus_rdata after the rising edge that takes the request. The bench applies every input at a falling edge and compares at the next falling edge, which is one rising edge later, against a model that is advanced once per cycle. This puts every comparison in the first cycle where the value is due and keeps it clear of the edge where the value changes.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int ADDR_W   = 14;
   localparam int MAX_SRC  = 256;
   localparam int MAX_CPU  = 32;
   localparam int PIDX_W   = 6;

   localparam logic [ADDR_W-1:0] A_CFG  = 14'h0000;
   localparam logic [ADDR_W-1:0] A_TRIG = 14'h0004;
   localparam logic [ADDR_W-1:0] A_PEND = 14'h0100;
   localparam logic [ADDR_W-1:0] A_EN   = 14'h0140;
   localparam logic [ADDR_W-1:0] A_ESET = 14'h0180;
   localparam logic [ADDR_W-1:0] A_ECLR = 14'h01C0;

   // position of the lowest set bit; 0 for an all-zero word
   function automatic logic [5:0] lowest_set(input logic [31:0] v);
      logic [5:0] r;
      r = '0;
      for (int b = 31; b >= 0; b--) begin
         if (v[b]) r = 6'(b);
      end
      return r;
   endfunction
endpackage

// File: rtl/sirq_src.sv
module sirq_src
   import sirq_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int NUM_PIN = 6,
   parameter int CPU_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_lvl,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic              trig_hit,
   input  logic              pin_we,
   input  logic              cpu_we,
   input  logic [31:0]       wdata,
   output logic              en,
   output logic              pend,
   output logic              pin_flag,
   output logic [PIDX_W-1:0] pin_idx,
   output logic              cpu_valid,
   output logic [CPU_W-1:0]  cpu_idx
);
   logic       hw_q;
   logic [5:0] low_bit;
   logic       pin_ok;

   always_comb begin
      low_bit = lowest_set(wdata);
      pin_ok  = int'(wdata[PIDX_W-1:0]) < NUM_PIN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hw_q      <= 1'b0;
         pend      <= 1'b0;
         en        <= 1'b0;
         pin_flag  <= 1'b1;
         pin_idx   <= '0;
         cpu_valid <= 1'b0;
         cpu_idx   <= '0;
      end else begin
         hw_q <= hw_lvl;
         // a level change on the wire has priority over a trigger write
         if (hw_lvl != hw_q)
            pend <= hw_lvl;
         else if (trig_hit)
            pend <= wdata[31];

         if (set_en)
            en <= 1'b1;
         else if (clr_en)
            en <= 1'b0;

         if (pin_we && pin_ok) begin
            pin_flag <= wdata[31];
            pin_idx  <= wdata[PIDX_W-1:0];
         end

         if (cpu_we) begin
            if (wdata == '0)
               cpu_valid <= 1'b0;
            else if (int'(low_bit) < NUM_CPU) begin
               cpu_valid <= 1'b1;
               cpu_idx   <= CPU_W'(low_bit);
            end
         end
      end
   end
endmodule

// File: rtl/sirq_fanin.sv
module sirq_fanin
   import sirq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 4,
   parameter int NUM_PIN = 6,
   parameter int CPU_W   = 2
) (
   input  logic [NUM_SRC-1:0]             en_vec,
   input  logic [NUM_SRC-1:0]             pend_vec,
   input  logic [NUM_SRC-1:0][PIDX_W-1:0] pin_idx,
   input  logic [NUM_SRC-1:0]             cpu_valid,
   input  logic [NUM_SRC-1:0][CPU_W-1:0]  cpu_idx,
   output logic [NUM_CPU*NUM_PIN-1:0]     irq_out
);
   logic [NUM_SRC-1:0] live;
   assign live = en_vec & pend_vec;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_SRC-1:0] cpu_hit;
      if (NUM_CPU == 1) begin : g_single
         assign cpu_hit = cpu_valid;
      end else begin : g_multi
         always_comb begin
            for (int i = 0; i < NUM_SRC; i++)
               cpu_hit[i] = cpu_valid[i] && (cpu_idx[i] == CPU_W'(c));
         end
      end
      for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
         logic acc;
         always_comb begin
            acc = 1'b0;
            for (int i = 0; i < NUM_SRC; i++)
               if (live[i] && cpu_hit[i] && (pin_idx[i] == PIDX_W'(p)))
                  acc = 1'b1;
         end
         assign irq_out[c*NUM_PIN+p] = acc;
      end
   end
endmodule

// File: rtl/sirq_rdmux.sv
module sirq_rdmux
   import sirq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 4,
   parameter int CPU_W   = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [NUM_SRC-1:0]             en_vec,
   input  logic [NUM_SRC-1:0]             pend_vec,
   input  logic [NUM_SRC-1:0]             pin_flag,
   input  logic [NUM_SRC-1:0][PIDX_W-1:0] pin_idx,
   input  logic [NUM_SRC-1:0]             cpu_valid,
   input  logic [NUM_SRC-1:0][CPU_W-1:0]  cpu_idx,
   output logic [31:0]                    rdata
);
   logic [MAX_SRC-1:0] en_pad, pend_pad;
   logic [2:0]         widx;
   logic               word_ok;
   logic [31:0]        rval;

   always_comb begin
      en_pad   = MAX_SRC'(en_vec);
      pend_pad = MAX_SRC'(pend_vec);
      widx     = addr[4:2];
      word_ok  = ((int'(widx) + 1) * 32) <= NUM_SRC;
      rval     = '0;
      if (addr[1:0] != 2'b00) begin
         rval = '0;
      end else if (addr[13:2] == A_CFG[13:2]) begin
         rval = {16'h0, 8'(NUM_SRC/8 - 1), 8'(NUM_CPU)};
      end else if (addr[13:5] == A_PEND[13:5]) begin
         if (word_ok) rval = pend_pad[int'(widx)*32 +: 32];
      end else if (addr[13:5] == A_EN[13:5]) begin
         if (word_ok) rval = en_pad[int'(widx)*32 +: 32];
      end else if (addr[13:10] == 4'h1) begin
         for (int i = 0; i < NUM_SRC; i++)
            if (addr[9:2] == 8'(i))
               rval = {pin_flag[i], 25'h0, pin_idx[i]};
      end else if (addr[13]) begin
         for (int i = 0; i < NUM_SRC; i++)
            if (addr[12:5] == 8'(i) && cpu_valid[i])
               rval = 32'd1 << cpu_idx[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= rval;
   end
endmodule

// File: rtl/sirq_router.sv
module sirq_router
   import sirq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 4,
   parameter int NUM_PIN = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_sel,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_SRC-1:0]         src_in,
   output logic [NUM_CPU*NUM_PIN-1:0] irq_out
);
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

   if ((NUM_SRC % 8) != 0 || NUM_SRC < 8 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must be a nonzero multiple of 8 no larger than 256");
   end
   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..32");
   end
   if (NUM_PIN < 1 || NUM_PIN > (1 << PIDX_W)) begin : g_bad_pin
      $error("NUM_PIN must lie in 1..64");
   end

   logic                           wr, rd, aligned, word_ok;
   logic                           in_set, in_clr, in_pin, in_cpu, is_trig;
   logic [2:0]                     widx;
   logic [NUM_SRC-1:0]             set_en, clr_en, trig_hit, pin_we, cpu_we;
   logic [NUM_SRC-1:0]             en_vec, pend_vec, pin_flag, cpu_valid;
   logic [NUM_SRC-1:0][PIDX_W-1:0] pin_idx;
   logic [NUM_SRC-1:0][CPU_W-1:0]  cpu_idx;

   always_comb begin
      aligned = bus_addr[1:0] == 2'b00;
      wr      = bus_sel && bus_we && aligned;
      rd      = bus_sel && !bus_we;
      widx    = bus_addr[4:2];
      word_ok = ((int'(widx) + 1) * 32) <= NUM_SRC;
      in_set  = wr && word_ok && (bus_addr[13:5] == A_ESET[13:5]);
      in_clr  = wr && word_ok && (bus_addr[13:5] == A_ECLR[13:5]);
      in_pin  = wr && (bus_addr[13:10] == 4'h1);
      in_cpu  = wr && bus_addr[13];
      is_trig = wr && (bus_addr[13:2] == A_TRIG[13:2]);
      for (int i = 0; i < NUM_SRC; i++) begin
         set_en[i]   = in_set && (widx == 3'(i / 32)) && bus_wdata[i % 32];
         clr_en[i]   = in_clr && (widx == 3'(i / 32)) && bus_wdata[i % 32];
         pin_we[i]   = in_pin && (bus_addr[9:2] == 8'(i));
         cpu_we[i]   = in_cpu && (bus_addr[12:5] == 8'(i));
         trig_hit[i] = is_trig && (bus_wdata[30:0] == 31'(i));
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      sirq_src #(
         .NUM_CPU (NUM_CPU),
         .NUM_PIN (NUM_PIN),
         .CPU_W   (CPU_W)
      ) u_src (
         .clk       (clk),
         .rst_n     (rst_n),
         .hw_lvl    (src_in[s]),
         .set_en    (set_en[s]),
         .clr_en    (clr_en[s]),
         .trig_hit  (trig_hit[s]),
         .pin_we    (pin_we[s]),
         .cpu_we    (cpu_we[s]),
         .wdata     (bus_wdata),
         .en        (en_vec[s]),
         .pend      (pend_vec[s]),
         .pin_flag  (pin_flag[s]),
         .pin_idx   (pin_idx[s]),
         .cpu_valid (cpu_valid[s]),
         .cpu_idx   (cpu_idx[s])
      );
   end

   sirq_fanin #(
      .NUM_SRC (NUM_SRC),
      .NUM_CPU (NUM_CPU),
      .NUM_PIN (NUM_PIN),
      .CPU_W   (CPU_W)
   ) u_fanin (
      .en_vec    (en_vec),
      .pend_vec  (pend_vec),
      .pin_idx   (pin_idx),
      .cpu_valid (cpu_valid),
      .cpu_idx   (cpu_idx),
      .irq_out   (irq_out)
   );

   sirq_rdmux #(
      .NUM_SRC (NUM_SRC),
      .NUM_CPU (NUM_CPU),
      .CPU_W   (CPU_W)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (rd),
      .addr      (bus_addr),
      .en_vec    (en_vec),
      .pend_vec  (pend_vec),
      .pin_flag  (pin_flag),
      .pin_idx   (pin_idx),
      .cpu_valid (cpu_valid),
      .cpu_idx   (cpu_idx),
      .rdata     (bus_rdata)
   );
endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk
   import sirq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 4,
   parameter int NUM_PIN = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_sel,
   input logic                       bus_we,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [PIDX_W-1:0]          wd_lo,
   input logic [31:0]                bus_rdata,
   input logic [NUM_CPU*NUM_PIN-1:0] irq_out,
   input logic [NUM_SRC-1:0]         en_vec,
   input logic [PIDX_W-1:0]          pin_idx0
);
   // R3: setting bit 0 of the first set-enable word enables source 0
   assert_set_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == A_ESET && wd_lo[0]) |=> en_vec[0]);

   // R4: clearing bit 0 of the first clear-enable word disables source 0
   assert_clr_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == A_ECLR && wd_lo[0]) |=> !en_vec[0]);

   // R6: an out-of-range pin index leaves source 0's pin unchanged
   assert_pin_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == 14'h0400 && int'(wd_lo) >= NUM_PIN)
      |=> $stable(pin_idx0));

   // R7: a processor slot always reads back one-hot or zero
   assert_cpu_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr[13]) |=> $onehot0(bus_rdata));

   // R10: with no source enabled, every output is low
   assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(en_vec) == 0) |-> (irq_out == '0));

   // R11: an unused address reads as zero
   assert_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 14'h0008) |=> (bus_rdata == '0));
endmodule

bind sirq_router sirq_router_chk #(
   .NUM_SRC (NUM_SRC),
   .NUM_CPU (NUM_CPU),
   .NUM_PIN (NUM_PIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .wd_lo     (bus_wdata[5:0]),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .en_vec    (en_vec),
   .pin_idx0  (pin_idx[0])
);

// File: tb/sirq_router_bench.sv
module sirq_router_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_SRC = 64;
   localparam int NUM_CPU = 4;
   localparam int NUM_PIN = 6;
   localparam int NOUT = NUM_CPU * NUM_PIN;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic               rst_n;
   logic               bus_sel, bus_we;
   logic [13:0]        bus_addr;
   logic [31:0]        bus_wdata, bus_rdata;
   logic [NUM_SRC-1:0] src_in;
   logic [NOUT-1:0]    irq_out;

   sirq_router #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN)) u_sirq_router (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_in(src_in), .irq_out(irq_out));

   bit m_en[NUM_SRC], m_pend[NUM_SRC], m_prev[NUM_SRC], m_flag[NUM_SRC], m_cv[NUM_SRC];
   int m_idx[NUM_SRC], m_ci[NUM_SRC];
   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int lowest(input logic [31:0] v);
      for (int b = 0; b < 32; b++) if (v[b]) return b;
      return 32;
   endfunction

   function automatic logic [31:0] exp_read(input int a);
      logic [31:0] r = '0;
      int w = (a >> 2) & 7;
      int s;
      if ((a & 3) != 0) return '0;
      if (a == 0) return {16'h0, 8'(NUM_SRC/8 - 1), 8'(NUM_CPU)};
      if ((a >> 5) == 8 || (a >> 5) == 10) begin
         if ((w + 1) * 32 > NUM_SRC) return '0;
         for (int b = 0; b < 32; b++)
            r[b] = ((a >> 5) == 8) ? m_pend[w*32+b] : m_en[w*32+b];
         return r;
      end
      if ((a >> 10) == 1) begin
         s = (a >> 2) & 255;
         if (s < NUM_SRC) r = {m_flag[s], 25'h0, 6'(m_idx[s])};
         return r;
      end
      if (a >= 32'h2000) begin
         s = (a >> 5) & 255;
         if (s < NUM_SRC && m_cv[s]) r = 32'd1 << m_ci[s];
         return r;
      end
      return '0;
   endfunction

   function automatic logic [NOUT-1:0] exp_irq();
      logic [NOUT-1:0] r = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (m_en[i] && m_pend[i] && m_cv[i]) r[m_ci[i]*NUM_PIN + m_idx[i]] = 1'b1;
      return r;
   endfunction

   // advance the model by one rising edge with the inputs that edge saw
   task automatic model_edge(input logic sel, input logic we, input int a, input logic [31:0] d);
      bit wr = sel && we && ((a & 3) == 0);
      int w = (a >> 2) & 7;
      int t = int'(d[30:0]);
      int lb;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (src_in[i] != m_prev[i]) m_pend[i] = src_in[i];
         else if (wr && a == 4 && t == i) m_pend[i] = d[31];
         m_prev[i] = src_in[i];
      end
      if (!wr) return;
      if (((a >> 5) == 12 || (a >> 5) == 14) && (w + 1) * 32 <= NUM_SRC)
         for (int b = 0; b < 32; b++)
            if (d[b]) m_en[w*32+b] = ((a >> 5) == 12);
      if ((a >> 10) == 1 && ((a >> 2) & 255) < NUM_SRC && int'(d[5:0]) < NUM_PIN) begin
         m_flag[(a >> 2) & 255] = d[31];
         m_idx[(a >> 2) & 255] = int'(d[5:0]);
      end
      if (a >= 32'h2000 && ((a >> 5) & 255) < NUM_SRC) begin
         lb = lowest(d);
         if (d == 0) m_cv[(a >> 5) & 255] = 1'b0;
         else if (lb < NUM_CPU) begin
            m_cv[(a >> 5) & 255] = 1'b1;
            m_ci[(a >> 5) & 255] = lb;
         end
      end
   endtask

   task automatic cyc(input logic sel, input logic we, input int a, input logic [31:0] d);
      bus_sel = sel; bus_we = we; bus_addr = 14'(a); bus_wdata = d;
      @(negedge clk);
      model_edge(sel, we, a, d);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      cyc(1'b1, 1'b1, a, d);
   endtask

   task automatic chk_rd(input string tag, input int a, input logic [31:0] exp);
      cyc(1'b1, 1'b0, a, 32'h0);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic chk_irq(input string tag, input logic [NOUT-1:0] exp);
      chk(tag, 32'(irq_out), 32'(exp));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         m_en[i] = 0; m_pend[i] = 0; m_prev[i] = 0; m_flag[i] = 1; m_idx[i] = 0; m_cv[i] = 0; m_ci[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      chk_rd("R1 config word", 32'h000, 32'h0000_0704);
      chk_rd("R2 pending after reset", 32'h100, 32'h0);
      chk_rd("R2 enable after reset", 32'h140, 32'h0);
      chk_rd("R2 pin word after reset", 32'h414, 32'h8000_0000);
      chk_rd("R2 cpu slot after reset", 32'h20A0, 32'h0);
      chk_irq("R2 outputs after reset", '0);
      chk_rd("R11 unused address", 32'h008, 32'h0);
      chk_rd("R11 misaligned address", 32'h401, 32'h0);

      wr(32'h180, 32'h5);
      chk_rd("R3 set enables", 32'h140, 32'h5);
      wr(32'h180, 32'h0);
      chk_rd("R3 zero write no effect", 32'h140, 32'h5);
      wr(32'h1C0, 32'h1);
      chk_rd("R4 clear enable", 32'h140, 32'h4);
      wr(32'h1C0, 32'h0);
      chk_rd("R4 zero write no effect", 32'h140, 32'h4);

      chk_rd("R5 rejected pending word", 32'h108, 32'h0);
      wr(32'h188, 32'hFFFF_FFFF);
      chk_rd("R5 rejected set word low", 32'h140, 32'h4);
      chk_rd("R5 rejected set word high", 32'h144, 32'h0);

      wr(32'h408, 32'hFFFF_FF03);
      chk_rd("R6 pin store", 32'h408, 32'h8000_0003);
      wr(32'h408, 32'h0000_0007);
      chk_rd("R6 pin out of range ignored", 32'h408, 32'h8000_0003);
      wr(32'h408, 32'h0000_0005);
      chk_rd("R6 highest pin accepted", 32'h408, 32'h0000_0005);
      wr(32'h408, 32'h8000_0003);

      wr(32'h2040, 32'h0000_000C);
      chk_rd("R7 lowest set bit", 32'h2040, 32'h4);
      wr(32'h2044, 32'h0000_0100);
      chk_rd("R7 cpu out of range ignored", 32'h205C, 32'h4);
      wr(32'h2040, 32'h0);
      chk_rd("R7 zero unmaps", 32'h2040, 32'h0);
      wr(32'h2040, 32'h2);

      chk_irq("R10 idle before trigger", '0);
      wr(32'h004, 32'h8000_0002);
      chk_irq("R10 routed to cpu1 pin3", NOUT'(1) << 9);
      chk_rd("R8 trigger set", 32'h100, 32'h4);
      wr(32'h004, 32'h8000_0040);
      chk_rd("R8 out of range trigger", 32'h100, 32'h4);
      wr(32'h004, 32'h8000_0010);
      chk_rd("R8 trigger set src16", 32'h100, 32'h0001_0004);
      wr(32'h004, 32'h0000_0010);
      chk_rd("R8 trigger clear", 32'h100, 32'h4);

      wr(32'h1C0, 32'h4);
      chk_irq("R10 disable drops output", '0);
      wr(32'h180, 32'h4);
      chk_irq("R10 re-enable", NOUT'(1) << 9);
      wr(32'h2040, 32'h0);
      chk_irq("R10 unmapped source silent", '0);
      wr(32'h2040, 32'h2);

      wr(32'h180, 32'h20);
      wr(32'h20A0, 32'h1);
      src_in[5] = 1'b1;
      cyc(1'b0, 1'b0, 0, 32'h0);
      chk_irq("R9 hardware level raises", (NOUT'(1) << 9) | NOUT'(1));
      chk_rd("R9 hardware pending", 32'h100, 32'h24);
      wr(32'h004, 32'h0000_0005);
      chk_rd("R9 trigger clears held level", 32'h100, 32'h4);
      src_in[5] = 1'b0;
      wr(32'h004, 32'h8000_0005);
      chk_rd("R9 falling level beats trigger set", 32'h100, 32'h4);
      src_in[5] = 1'b1;
      wr(32'h004, 32'h0000_0005);
      chk_rd("R9 rising level beats trigger clear", 32'h100, 32'h24);

      for (int n = 0; n < 1500; n++) begin
         int op = int'($urandom % 8);
         int a;
         logic [31:0] d, e;
         if (op != 6 && ($urandom % 4) == 0) begin
            int b = int'($urandom % NUM_SRC);
            src_in[b] = ~src_in[b];
         end
         case (op)
            0: wr(32'h180 + 4 * int'($urandom % 3), $urandom);
            1: wr(32'h1C0 + 4 * int'($urandom % 3), $urandom & $urandom);
            2, 3: begin
               d = {1'($urandom), 31'($urandom % 80)};
               wr(32'h004, d);
            end
            4: wr(32'h400 + 4 * int'($urandom % 64), ($urandom & 32'hFFFF_FFC0) | ($urandom % 8));
            5: begin
               a = 32'h2000 + 32 * int'($urandom % 64) + 4 * int'($urandom % 8);
               case ($urandom % 3)
                  0: d = 32'h0;
                  1: d = 32'd1 << ($urandom % 6);
                  default: d = $urandom;
               endcase
               wr(a, d);
            end
            6: begin
               case ($urandom % 6)
                  0: a = 32'h100 + 4 * int'($urandom % 3);
                  1: a = 32'h140 + 4 * int'($urandom % 3);
                  2: a = 32'h400 + 4 * int'($urandom % 64);
                  3: a = 32'h2000 + 32 * int'($urandom % 64);
                  4: a = 0;
                  default: a = int'($urandom % 32'h4000);
               endcase
               e = exp_read(a);
               chk_rd("R11 random readback", a, e);
            end
            default: cyc(1'b0, 1'b0, 0, 32'h0);
         endcase
         chk_irq("R10 random output", exp_irq());
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule